// File: doc/BRIEF.md
# Force Wake-up Pin Debouncer

This block turns a single active-low wake-up pin into a clean wake-up event. The pin is asynchronous to the slow clock of about 32 kHz that runs the block. It first passes through a two-flop synchroniser. A counter then measures how long the synchronised pin has stayed low while the block is enabled. When the low time reaches the length picked by a 3-bit select field, the block emits a one-cycle wake-up pulse. At the same time it sets a sticky flag, which stays high until a status read clears it.

The pulse fires once for each low period of the pin. The counter re-arms only after the pin has been seen high, or after the enable has dropped. A low period that ends early throws away the partial count, so the next low period starts again from zero. Register decode, power sequencing and pad behaviour are handled around the block.

Top module: `fwake_debouncer`

## Requirements
- R1: After reset, `wake_pulse` and `wake_flag` are both 0.
- R2: Select codes 1, 2, 3, 4 and 5 need the synchronised pin low for 3, 32, 512, 4096 and 32768 consecutive clock cycles. With the pin held low from a first sampling edge E0, `wake_pulse` is high in the cycle after edge E(N+1), where N is the selected length. Two of these edges come from the synchroniser.
- R3: Select codes 0, 6 and 7 give an immediate wake. One synchronised low cycle is enough (N = 1).
- R4: While `enable` is 0, the pin has no effect: no pulse and no flag, however long it stays low.
- R5: If the pin rises before N synchronised low cycles, the count is discarded. A pin held low for N-1 sampling edges gives no wake. The next low period again needs the full N cycles.
- R6: One continuous low period gives at most one pulse. A new pulse needs the pin to be seen high first.
- R7: `wake_pulse` is high for exactly one clock cycle per wake.
- R8: `wake_flag` rises together with `wake_pulse` and stays high until a cycle with `status_rd` = 1. It reads 0 from the following cycle.
- R9: When a wake and `status_rd` fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 lets the pin take part in wake-up |
| dbc_sel | input | 3 | Debounce length select code |
| pin_n | input | 1 | Raw wake-up pin, active low, asynchronous |
| status_rd | input | 1 | Status read strobe, clears the sticky flag |
| wake_pulse | output | 1 | One-cycle wake-up event |
| wake_flag | output | 1 | Sticky wake-up status |

## Verification
A counter that resets or compares wrongly shows at the ports as a pulse that comes early, comes late or never comes. The bench measures the edge distance from the pin falling to the pulse, so an off-by-one is seen on that very wake. A lost disarm state shows within one cycle as a second pulse during the same low period. A wrong flag priority shows in the cycle right after a read that coincides with a wake.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SEL_W = 3;
  localparam int LIM_W = 16;

  // Debounce length in slow-clock cycles for a select code.
  function automatic logic [LIM_W-1:0] fwd_limit(input logic [SEL_W-1:0] code);
    logic [LIM_W-1:0] lim;
    case (code)
      3'd1:    lim = LIM_W'(3);
      3'd2:    lim = LIM_W'(32);
      3'd3:    lim = LIM_W'(512);
      3'd4:    lim = LIM_W'(4096);
      3'd5:    lim = LIM_W'(32768);
      default: lim = LIM_W'(1);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/fwd_counter.sv
module fwd_counter
  import fwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             fire,
  output logic             armed
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit_w;
  logic             armed_q;
  logic             reached;

  assign limit_w = CNT_W'(fwd_limit(sel));
  assign cnt_inc = cnt_q + 1'b1;
  assign reached = (cnt_inc >= limit_w);
  assign fire    = active && armed_q && reached;
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!active) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      if (reached) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  // R5
  inactive_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0) && armed_q);
  // R6
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sel) |-> (cnt_q < limit_w));
endmodule

// File: rtl/fwd_flag.sv
module fwd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_rd,
  output logic pulse,
  output logic flag
);
  logic pulse_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= set_ev;
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_rd) flag_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> pulse_q);
  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_rd) && !pulse_q);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> flag_q);
endmodule

// File: rtl/fwake_debouncer.sv
module fwake_debouncer
  import fwd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] dbc_sel,
  input  logic             pin_n,
  input  logic             status_rd,
  output logic             wake_pulse,
  output logic             wake_flag
);
  logic pin_s;
  logic active;
  logic fire;
  logic armed;

  fwd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_n),
    .d_out (pin_s)
  );

  assign active = enable && !pin_s;

  fwd_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .sel    (dbc_sel),
    .fire   (fire),
    .armed  (armed)
  );

  fwd_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (fire),
    .clr_rd (status_rd),
    .pulse  (wake_pulse),
    .flag   (wake_flag)
  );

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> $past(enable));
  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && active |=> !wake_pulse);
endmodule

// File: tb/fwake_debouncer_tb.sv
module fwake_debouncer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] dbc_sel = 3'd0;
  logic       pin_n = 1'b1;
  logic       status_rd = 1'b0;
  logic       wake_pulse;
  logic       wake_flag;

  int n_chk = 0;
  int n_bad = 0;

  localparam int NROW = 8;
  localparam logic [2:0] ROW_SEL [NROW] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int ROW_LEN [NROW] = '{1, 3, 32, 512, 4096, 32768, 1, 1};

  always #4 clk = ~clk;

  fwake_debouncer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dbc_sel(dbc_sel),
    .pin_n(pin_n), .status_rd(status_rd),
    .wake_pulse(wake_pulse), .wake_flag(wake_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Edges from pin low to first pulse, 0 if none within lim.
  task automatic time_wake(input int lim, output int k);
    k = 0;
    pin_n = 1'b0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (wake_pulse && k == 0) k = i;
    end
  endtask

  task automatic idle_and_clear();
    pin_n = 1'b1;
    cycles(4);
    status_rd = 1'b1;
    cycles(1);
    status_rd = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int k;
    int ones;
    cycles(3);
    // R1 reset state
    check("R1 pulse", wake_pulse, 0);
    check("R1 flag", wake_flag, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    cycles(2);

    // R2 / R3 table walk
    foreach (ROW_SEL[r]) begin
      dbc_sel = ROW_SEL[r];
      cycles(1);
      time_wake(ROW_LEN[r] + 2, k);
      check((ROW_LEN[r] == 1) ? "R3 latency" : "R2 latency", k, ROW_LEN[r] + 2);
      check("R8 flag set", wake_flag, 1);
      idle_and_clear();
    end

    // R6 / R7: long hold gives one single-cycle pulse
    dbc_sel = 3'd1;
    pin_n = 1'b0;
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ones += wake_pulse;
    end
    check("R6 R7 one pulse per hold", ones, 1);
    // R8 flag still sticky after pulse ends
    check("R8 sticky", wake_flag, 1);
    status_rd = 1'b1;
    cycles(1);
    status_rd = 1'b0;
    check("R8 cleared by read", wake_flag, 0);
    // R6 re-arm after pin high
    pin_n = 1'b1;
    cycles(3);
    time_wake(5, k);
    check("R6 re-arm", k, 5);
    idle_and_clear();

    // R5 glitch of N-1 edges, then full N needed
    dbc_sel = 3'd1;
    pin_n = 1'b0;
    cycles(2);
    pin_n = 1'b1;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ones += wake_pulse;
    end
    check("R5 short low no wake", ones, 0);
    check("R5 short low no flag", wake_flag, 0);
    time_wake(5, k);
    check("R5 full count again", k, 5);
    idle_and_clear();

    // R5 exactly N edges low is enough
    pin_n = 1'b0;
    cycles(3);
    pin_n = 1'b1;
    ones = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ones += wake_pulse;
    end
    check("R5 N edges wakes", ones, 1);
    idle_and_clear();

    // R4 disabled
    enable = 1'b0;
    pin_n = 1'b0;
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ones += wake_pulse;
    end
    check("R4 no pulse", ones, 0);
    check("R4 no flag", wake_flag, 0);
    pin_n = 1'b1;
    cycles(3);
    enable = 1'b1;

    // R9 set and read in the same cycle (immediate code)
    dbc_sel = 3'd0;
    cycles(1);
    pin_n = 1'b0;
    cycles(2);
    status_rd = 1'b1;
    cycles(1);
    status_rd = 1'b0;
    check("R9 pulse", wake_pulse, 1);
    check("R9 set wins", wake_flag, 1);
    idle_and_clear();
    check("R8 clear after read", wake_flag, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule